// File: doc/BRIEF.md
# Daisy-Chain Serial Update Master

This controller sits on the host side of a chain of serially addressed eight-channel register devices. The devices share one serial clock and one load strobe. Each device's serial input is fed from the serial output of the device before it. On a start request the master captures one command per device. A command is a 4-bit channel address and an 8-bit value. The master then shifts the whole chain's frame out, 12 bits per device, and ends with a single load strobe. On that strobe every device applies the command now held in its own shift register.

The command for the device farthest from the master leaves first. After 12×N rising edges each device therefore holds exactly its own command. A device that must not change is given address 0, which the devices treat as no operation. A programmable half-period divider sets the serial bit rate. Between updates the serial clock stays low, so the analog side sees no digital feedthrough.

Top module: `chain_update_master`

## Requirements
- R1: While reset is asserted and after it is released with no start request, sclk, sdo, ld, busy and done are all 0.
- R2: Each accepted start produces exactly 12×NDEV rising edges on sclk before the load strobe.
- R3: The frame carries the device NDEV-1 command first and the device 0 command last (device 0 is nearest the master). Each 12-bit group is sent MSB first: address bits [3:0] in cmd_addr[4d+3:4d], then data bits [7:0] in cmd_data[8d+7:8d]. After the strobe, every device given address 1..8 holds the value in channel address-1, and a device given address 0 keeps all its channels.
- R4: sdo changes only on the system clock edge where sclk falls, or while sclk is low. It is stable for the whole time sclk is high.
- R5: While shifting, sclk is high for half_div+1 system clocks and low for half_div+1 system clocks. The first low phase is counted from the cycle after start is accepted.
- R6: ld rises after the final rising sclk edge, while sclk is low. It stays high for exactly 2×(half_div+1) system clocks, and no sclk rising edge occurs while it is high.
- R7: busy is high from the cycle after an accepted start until done. done is a single-cycle pulse in the cycle immediately after ld falls. busy falls in the cycle after done.
- R8: A start request seen while busy is high is ignored. It starts no second sequence.
- R9: sclk is low whenever busy is low.
- R10: The commands and half_div are captured when start is accepted. Changes to them while busy have no effect on the current sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send one update to the chain |
| half_div | input | DIVW | Serial clock half-period, in system clocks, minus one |
| cmd_addr | input | 4×NDEV | Per-device channel address; device d uses bits [4d+3:4d] |
| cmd_data | input | 8×NDEV | Per-device value; device d uses bits [8d+7:8d] |
| sclk | output | 1 | Serial clock to the chain, idles low |
| sdo | output | 1 | Serial data to the first device |
| ld | output | 1 | Load strobe shared by all devices |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse at the end of an update |

## Verification
A wrong bit counter or a bad group order does not show at sclk. It shows only once the strobe fires: the wrong channels in the wrong devices take new values, or a device meant to stay untouched changes. For that reason the bench models the chain of devices behind the ports and compares every channel after each update. A divider or phase fault shows within one serial-clock half-period, as a high or low phase of the wrong length or as sdo moving while sclk is high. A sequencing fault shows in the strobe window: ld overlaps a rising sclk edge, has the wrong length, or done fails to follow it at once.

// File: rtl/chain_update_master.sv
module chain_update_master #(
  parameter int NDEV = 3,
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIVW-1:0]   half_div,
  input  logic [4*NDEV-1:0] cmd_addr,
  input  logic [8*NDEV-1:0] cmd_data,
  output logic              sclk,
  output logic              sdo,
  output logic              ld,
  output logic              busy,
  output logic              done
);
  localparam int FRAME = 12 * NDEV;
  localparam int CW    = $clog2(FRAME + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LOAD, S_FIN} state_t;

  state_t            state;
  logic [DIVW-1:0]   cnt, div_q;
  logic [FRAME-1:0]  frame_q, frame_w;
  logic [CW-1:0]     bitn;
  logic              sclk_q, lph;
  logic              tick;

  for (genvar d = 0; d < NDEV; d++) begin : g_grp
    assign frame_w[12*d +: 12] = {cmd_addr[4*d +: 4], cmd_data[8*d +: 8]};
  end

  assign tick = (cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      div_q   <= '0;
      frame_q <= '0;
      bitn    <= '0;
      sclk_q  <= 1'b0;
      lph     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          frame_q <= frame_w;
          div_q   <= half_div;
          cnt     <= '0;
          bitn    <= '0;
          sclk_q  <= 1'b0;
          state   <= S_SHIFT;
        end
        S_SHIFT: begin
          cnt <= tick ? '0 : cnt + 1'b1;
          if (tick) begin
            if (!sclk_q) sclk_q <= 1'b1;
            else begin
              sclk_q <= 1'b0;
              if (bitn == CW'(FRAME - 1)) begin
                state <= S_LOAD;
                lph   <= 1'b0;
              end else begin
                frame_q <= frame_q << 1;
                bitn    <= bitn + 1'b1;
              end
            end
          end
        end
        S_LOAD: begin
          cnt <= tick ? '0 : cnt + 1'b1;
          if (tick) begin
            if (lph) state <= S_FIN;
            else     lph   <= 1'b1;
          end
        end
        default: begin
          frame_q <= '0;
          state   <= S_IDLE;
        end
      endcase
    end
  end

  assign sclk = sclk_q;
  assign sdo  = (state == S_SHIFT) & frame_q[FRAME-1];
  assign ld   = (state == S_LOAD);
  assign done = (state == S_FIN);
  assign busy = (state != S_IDLE);
endmodule

module chain_update_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sclk,
  input logic sdo,
  input logic ld,
  input logic busy,
  input logic done
);
  // R9
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R6
  ld_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !sclk);
  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_after_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ld && $past(ld)));
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind chain_update_master chain_update_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .sdo(sdo),
  .ld(ld), .busy(busy), .done(done)
);

// File: tb/chain_update_master_tb.sv
`timescale 1ns/1ps
module chain_update_master_tb;
  localparam int NDEV = 3;
  localparam int DIVW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DIVW-1:0]   half_div = '0;
  logic [4*NDEV-1:0] cmd_addr = '0;
  logic [8*NDEV-1:0] cmd_data = '0;
  logic sclk, sdo, ld, busy, done;

  chain_update_master #(.NDEV(NDEV), .DIVW(DIVW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sclk(sclk), .sdo(sdo),
    .ld(ld), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural chain of devices: shift on sclk rise, apply on ld rise.
  logic [11:0] sr [NDEV];
  logic [7:0]  ch [NDEV][8];
  logic [7:0]  exp_ch [NDEV][8];
  initial begin
    for (int d = 0; d < NDEV; d++) begin
      sr[d] = '0;
      for (int c = 0; c < 8; c++) begin ch[d][c] = 8'h80; exp_ch[d][c] = 8'h80; end
    end
  end
  always @(posedge sclk) begin
    for (int d = NDEV-1; d > 0; d--) sr[d] <= {sr[d][10:0], sr[d-1][11]};
    sr[0] <= {sr[0][10:0], sdo};
  end
  always @(posedge ld) begin
    for (int d = 0; d < NDEV; d++)
      if (sr[d][11:8] >= 4'd1 && sr[d][11:8] <= 4'd8)
        ch[d][sr[d][11:8]-4'd1] = sr[d][7:0];
  end

  // Port monitor
  int rises, hi_len, lo_len, bad_hi, bad_lo, bad_sdo, ld_len, ld_last, bad_ldclk, bad_done, done_cnt, exp_h;
  logic p_sclk = 1'b0, p_sdo = 1'b0, p_ld = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && p_sclk && sdo !== p_sdo) bad_sdo++;
      if (sclk && !p_sclk) begin
        rises++;
        if (lo_len != exp_h) bad_lo++;
        lo_len = 0;
        if (ld) bad_ldclk++;
      end
      if (!sclk && p_sclk) begin
        if (hi_len != exp_h) bad_hi++;
        hi_len = 0;
      end
      if (sclk) hi_len++;
      if (busy && !sclk && !ld && !done) lo_len++;
      if (ld && !p_ld && sclk) bad_ldclk++;
      if (ld) ld_len++;
      if (!ld && p_ld) begin
        ld_last = ld_len;
        ld_len = 0;
        if (!done) bad_done++;
      end
      if (done) done_cnt++;
    end
    p_sclk = sclk; p_sdo = sdo; p_ld = ld;
  end

  task automatic clear_mon(input int div);
    rises = 0; hi_len = 0; lo_len = 0; bad_hi = 0; bad_lo = 0; bad_sdo = 0;
    ld_len = 0; ld_last = 0; bad_ldclk = 0; bad_done = 0; done_cnt = 0; exp_h = div + 1;
  endtask

  task automatic set_exp(input logic [4*NDEV-1:0] a, input logic [8*NDEV-1:0] v);
    for (int d = 0; d < NDEV; d++)
      if (a[4*d +: 4] >= 4'd1 && a[4*d +: 4] <= 4'd8)
        exp_ch[d][a[4*d +: 4]-4'd1] = v[8*d +: 8];
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic check_update(input string tag);
    int mism = 0;
    chk(rises == 12*NDEV, {tag, " R2 sclk rises"}, rises, 12*NDEV);
    chk(bad_hi == 0 && bad_lo == 0, {tag, " R5 phase length errors"}, bad_hi + bad_lo, 0);
    chk(bad_sdo == 0, {tag, " R4 sdo moved while sclk high"}, bad_sdo, 0);
    chk(ld_last == 2*exp_h, {tag, " R6 ld width"}, ld_last, 2*exp_h);
    chk(bad_ldclk == 0, {tag, " R6 sclk during ld"}, bad_ldclk, 0);
    chk(done_cnt == 1 && bad_done == 0, {tag, " R7 done pulse"}, done_cnt, 1);
    chk(!busy && !sclk, {tag, " R9 idle after update"}, {busy, sclk}, 0);
    for (int d = 0; d < NDEV; d++)
      for (int c = 0; c < 8; c++)
        if (ch[d][c] !== exp_ch[d][c]) mism++;
    chk(mism == 0, {tag, " R3 channel contents"}, mism, 0);
  endtask

  task automatic do_update(input logic [4*NDEV-1:0] a, input logic [8*NDEV-1:0] v,
                           input int div, input string tag);
    @(negedge clk);
    clear_mon(div);
    cmd_addr = a; cmd_data = v; half_div = DIVW'(div); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, {tag, " R7 busy after start"}, busy, 1);
    set_exp(a, v);
    wait_done();
    check_update(tag);
  endtask

  task automatic t_reset();
    #1;
    chk({sclk, sdo, ld, busy, done} == 5'b0, "R1 outputs in reset", {sclk, sdo, ld, busy, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({sclk, sdo, ld, busy, done} == 5'b0, "R1 outputs after reset", {sclk, sdo, ld, busy, done}, 0);
  endtask

  task automatic t_basic();
    do_update({4'd1, 4'd8, 4'd3}, {8'hA5, 8'h3C, 8'hF0}, 0, "basic");
  endtask

  task automatic t_nop_slow();
    do_update({4'd5, 4'd0, 4'd2}, {8'h11, 8'hFF, 8'h7E}, 3, "nop");
  endtask

  task automatic t_reserved();
    do_update({4'd12, 4'd4, 4'd0}, {8'h99, 8'h01, 8'hEE}, 1, "reserved");
  endtask

  task automatic t_busy_start();
    logic [4*NDEV-1:0] a = {4'd7, 4'd6, 4'd1};
    logic [8*NDEV-1:0] v = {8'h5A, 8'hC3, 8'h00};
    int restarted = 0;
    @(negedge clk);
    clear_mon(2);
    cmd_addr = a; cmd_data = v; half_div = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    set_exp(a, v);
    repeat (40) @(negedge clk);
    // R8 / R10: second request and new inputs mid-sequence
    cmd_addr = {4'd2, 4'd2, 4'd2}; cmd_data = {8'h12, 8'h34, 8'h56}; half_div = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_update("busy_start R10");
    repeat (20) @(negedge clk) if (busy) restarted++;
    chk(restarted == 0, "R8 start while busy ignored", restarted, 0);
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_nop_slow();
    t_reserved();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule